// File: doc/BRIEF.md
# Serial PHY Management Master with Local Register Window

This block lets a host read and write 16-bit management registers in external Ethernet PHYs over the two-wire management bus (a clock line and a bidirectional data line). The host presents a 6-bit PHY address, a 6-bit register location, write data and a read/write select, then pulses a request strobe. The block raises `busy_o`, derives the management clock from the system clock, shifts out a full frame and, for reads, returns the captured value on `rdata_o` when `busy_o` falls.

PHY address 32 never goes onto the wire. It selects an on-chip bank of eight 16-bit registers. Locations 0 to 5 and 16 to 17 each map to one of these registers. Every other location reads as zero and takes no writes. Such an access completes on the edge that accepts it, and the bus stays idle.

The data line is given as an output value, an output enable and an input, so the pad or a testbench can build the open line with its pull-up.

Top module: `mdio_master`

## Requirements
- R1: Every serial frame opens with exactly 32 cycles of the management clock in which the master drives the data line to 1.
- R2: A read frame drives 14 bits after the opening run: 0,1 (start), 1,0 (read), the PHY address bits 4..0, then the location bits 4..0, most significant bit first. It then releases the line for 19 clock cycles.
- R3: During a read, the 16 bits sampled in the 3rd through 18th released cycles, MSB first, become `rdata_o` when `busy_o` falls. The two turnaround bits and the final idle bit are discarded. A PHY that does not answer yields 16'hFFFF because the line is pulled up.
- R4: A write frame drives 32 bits after the opening run: 0,1, 0,1, PHY address[4:0], location[4:0], 1,0, then write data[15:0], MSB first. Two further clock cycles follow with the line released.
- R5: Each half of the management clock lasts `CLK_DIV` system cycles. The default of 10 gives 2.5 MHz from a 50 MHz clock.
- R6: The master changes its driven data bit and its output enable only on a falling edge of the management clock. Input bits are sampled at the rising edge.
- R7: `busy_o` rises on the edge after an accepted serial request. It stays high for (65 for a read, 66 for a write) × 2 × `CLK_DIV` cycles. A request made while `busy_o` is high is ignored.
- R8: With PHY address 32, locations 0–5 reach local slots 0–5, location 16 reaches slot 6 and location 17 reaches slot 7. A read puts the slot on `rdata_o` one cycle after the request.
- R9: With PHY address 32, a read of any unmapped location returns 0. A write to one changes no slot.
- R10: A request with location above 32 or PHY address above 32 is dropped. `busy_o` stays low, the clock does not toggle and `rdata_o` is unchanged.
- R11: Local window accesses keep `busy_o` low and produce no clock edges or driven bits. When idle, the clock is low and the output enable is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | One-cycle request strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| phy_addr_i | input | 6 | PHY address, 32 selects the local window |
| reg_loc_i | input | 6 | Register location |
| wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Serial transaction in progress |
| rdata_o | output | 16 | Last read result |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data value driven by the master |
| mdio_oe_o | output | 1 | Master drives the data line when high |
| mdio_i | input | 1 | Sampled level of the data line |

## Verification
The bench attaches a behavioural PHY that decodes frames bit by bit, keeps 32 registers and answers reads after a one-bit turnaround. This catches a frame whose opening run, opcode or field order is off, and a capture window shifted by one bit, which would return a value shifted by a turnaround bit.

It counts driven and released clock cycles per frame, so a missing or extra trailing clock after a write shows up. It reads from an absent PHY and expects all ones.

It fires a second request mid-frame; a design that accepted it would corrupt the frame or issue a second write. It writes to unmapped and mapped local locations, so an aliasing slot decoder would overwrite a neighbour. It also issues out-of-range requests, which a careless design would still put on the wire.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int CLK_DIV = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_i,
  input  logic        wr_i,
  input  logic [5:0]  phy_addr_i,
  input  logic [5:0]  reg_loc_i,
  input  logic [15:0] wdata_i,
  output logic        busy_o,
  output logic [15:0] rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  localparam int CW = $clog2(CLK_DIV + 1);
  localparam logic [5:0] LOCAL_PHY = 6'd32;

  logic          busy_q, hi_q, wr_q;
  logic [CW-1:0] div_q;
  logic [6:0]    bit_q;
  logic [63:0]   tx_q;
  logic [15:0]   rx_q, rdata_q;
  logic [15:0]   bank [8];
  logic          slot_ok;
  logic [2:0]    slot;

  wire accept    = req_i && !busy_q;
  wire bad       = (reg_loc_i > 6'd32) || (phy_addr_i > 6'd32);
  wire local_acc = accept && !bad && (phy_addr_i == LOCAL_PHY);
  wire serial_go = accept && !bad && (phy_addr_i != LOCAL_PHY);
  wire half_end  = (div_q == CW'(CLK_DIV - 1));
  wire rise      = busy_q && half_end && !hi_q;
  wire fall      = busy_q && half_end && hi_q;
  wire [6:0] last_bit  = wr_q ? 7'd65 : 7'd64;
  wire [6:0] drive_cnt = wr_q ? 7'd64 : 7'd46;

  always_comb begin
    slot_ok = 1'b1;
    slot    = reg_loc_i[2:0];
    if (reg_loc_i == 6'd16)      slot = 3'd6;
    else if (reg_loc_i == 6'd17) slot = 3'd7;
    else if (reg_loc_i >= 6'd6)  slot_ok = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      hi_q    <= 1'b0;
      wr_q    <= 1'b0;
      div_q   <= '0;
      bit_q   <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      rdata_q <= '0;
      for (int i = 0; i < 8; i++) bank[i] <= '0;
    end else if (serial_go) begin
      busy_q <= 1'b1;
      hi_q   <= 1'b0;
      wr_q   <= wr_i;
      div_q  <= '0;
      bit_q  <= '0;
      tx_q   <= wr_i ? {32'hFFFF_FFFF, 4'b0101, phy_addr_i[4:0], reg_loc_i[4:0], 2'b10, wdata_i}
                     : {32'hFFFF_FFFF, 4'b0110, phy_addr_i[4:0], reg_loc_i[4:0], 18'h0};
    end else if (local_acc) begin
      if (wr_i) begin
        if (slot_ok) bank[slot] <= wdata_i;
      end else begin
        rdata_q <= slot_ok ? bank[slot] : 16'h0;
      end
    end else if (busy_q) begin
      div_q <= half_end ? '0 : div_q + 1'b1;
      if (rise) begin
        hi_q <= 1'b1;
        if (!wr_q && bit_q >= 7'd48 && bit_q <= 7'd63) rx_q <= {rx_q[14:0], mdio_i};
      end
      if (fall) begin
        hi_q <= 1'b0;
        if (bit_q == last_bit) begin
          busy_q <= 1'b0;
          if (!wr_q) rdata_q <= rx_q;
        end else begin
          bit_q <= bit_q + 1'b1;
          tx_q  <= {tx_q[62:0], 1'b0};
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign rdata_o   = rdata_q;
  assign mdc_o     = hi_q;
  assign mdio_oe_o = busy_q && (bit_q < drive_cnt);
  assign mdio_o    = mdio_oe_o & tx_q[63];
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int CLK_DIV = 10
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_i,
  input logic [5:0] phy_addr_i,
  input logic [5:0] reg_loc_i,
  input logic       busy_o,
  input logic       mdc_o,
  input logic       mdio_o,
  input logic       mdio_oe_o
);
  logic        mdc_q;
  logic [15:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mdc_q <= 1'b0;
      run   <= '0;
    end else begin
      mdc_q <= mdc_o;
      run   <= !busy_o ? 16'd0 : (mdc_o != mdc_q) ? 16'd1 : run + 16'd1;
    end
  end

  a_r11_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mdc_o && !mdio_oe_o));

  a_r6_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mdc_o) && mdio_oe_o) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

  a_r7_busy_from_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(req_i));

  a_r10_reject_range: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !busy_o && (reg_loc_i > 6'd32 || phy_addr_i > 6'd32)) |=> !busy_o);

  a_r5_half_period: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && (mdc_o != mdc_q)) |-> (run == 16'(CLK_DIV)));
endmodule

bind mdio_master mdio_master_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .phy_addr_i(phy_addr_i),
  .reg_loc_i(reg_loc_i), .busy_o(busy_o), .mdc_o(mdc_o),
  .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o)
);

// File: tb/mdio_master_test.sv
module mdio_master_test;
  localparam int CLK_DIV = 10;
  localparam logic [4:0] PHY = 5'd3;

  logic clk = 0, rst_n = 0, req = 0, wr = 0;
  logic [5:0] phy_a = 0, loc = 0;
  logic [15:0] wd = 0;
  logic busy, mdc, mdo, mdoe, mdi;
  logic [15:0] rdata;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  mdio_master #(.CLK_DIV(CLK_DIV)) uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .phy_addr_i(phy_a),
    .reg_loc_i(loc), .wdata_i(wd), .busy_o(busy), .rdata_o(rdata),
    .mdc_o(mdc), .mdio_o(mdo), .mdio_oe_o(mdoe), .mdio_i(mdi));

  // behavioural PHY
  logic phy_oe = 0, phy_d = 1, pend = 0;
  logic [63:0] hist = '0;
  logic [15:0] phy_regs [32];
  logic [15:0] rdat;
  int rcnt = 0, oe_rises = 0, rel_rises = 0, rd_seen = 0, wr_seen = 0;
  logic [4:0] rd_phy, rd_reg, wr_phy, wr_reg;
  logic [15:0] wr_dat;
  assign mdi = mdoe ? mdo : (phy_oe ? phy_d : 1'b1);

  initial for (int i = 0; i < 32; i++) phy_regs[i] = {5'(i), 6'b101100, ~5'(i)};

  always @(posedge mdc) begin
    if (mdoe) begin
      hist = {hist[62:0], mdo};
      oe_rises++;
      if (&hist[45:14] && hist[13:10] == 4'b0110) begin
        rd_seen++; rd_phy = hist[9:5]; rd_reg = hist[4:0];
        if (hist[9:5] == PHY) begin pend = 1; rcnt = 0; rdat = phy_regs[hist[4:0]]; end
      end
      if (&hist[63:32] && hist[31:28] == 4'b0101 && hist[17:16] == 2'b10) begin
        wr_seen++; wr_phy = hist[27:23]; wr_reg = hist[22:18]; wr_dat = hist[15:0];
        if (hist[27:23] == PHY) phy_regs[hist[22:18]] = hist[15:0];
      end
    end else rel_rises++;
  end

  always @(negedge mdc) if (pend) begin
    if (rcnt == 1) begin phy_oe = 1; phy_d = 0; end
    else if (rcnt >= 2 && rcnt <= 17) phy_d = rdat[17 - rcnt];
    else if (rcnt == 18) begin phy_oe = 0; pend = 0; end
    rcnt++;
  end

  // R6 monitor: driven bit must not move at a rising edge
  logic mdc_p = 0, mdo_p = 0;
  int r6_viol = 0;
  always @(negedge clk) begin
    if (mdc && !mdc_p && mdoe && mdo != mdo_p) r6_viol++;
    mdc_p = mdc; mdo_p = mdo;
  end

  task automatic chk(input string req_s, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req_s, act, exp);
    end
  endtask

  int busy_cyc, period, mdc_edges;
  task automatic run_op(input logic w, input logic [5:0] p, input logic [5:0] l, input logic [15:0] d);
    int last;
    logic prev;
    oe_rises = 0; rel_rises = 0; busy_cyc = 0; period = 0; mdc_edges = 0; last = -1; prev = 0;
    @(negedge clk); req = 1; wr = w; phy_a = p; loc = l; wd = d;
    @(negedge clk); req = 0;
    while (busy) begin
      if (mdc && !prev) begin
        mdc_edges++;
        if (last >= 0 && period == 0) period = busy_cyc - last;
        last = busy_cyc;
      end
      prev = mdc; busy_cyc++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R11 reset busy", busy, 0);
    chk("R11 reset mdc", mdc, 0);
    chk("R11 reset oe", mdoe, 0);
    chk("R3 reset rdata", rdata, 0);
  endtask

  task automatic t_read_ext;
    int rs = rd_seen;
    run_op(0, 6'(PHY), 6'd2, 0);
    chk("R2 read frame seen", rd_seen, rs + 1);
    chk("R2 phy field", rd_phy, PHY);
    chk("R2 reg field", rd_reg, 2);
    chk("R1 driven bits read", oe_rises, 46);
    chk("R2 released bits", rel_rises, 19);
    chk("R3 read data", rdata, {5'd2, 6'b101100, ~5'd2});
    chk("R7 busy read", busy_cyc, 65 * 2 * CLK_DIV);
    chk("R5 mdc period", period, 2 * CLK_DIV);
  endtask

  task automatic t_write_ext;
    int ws = wr_seen;
    run_op(1, 6'(PHY), 6'd9, 16'hA5C3);
    chk("R4 write frame seen", wr_seen, ws + 1);
    chk("R4 phy field", wr_phy, PHY);
    chk("R4 reg field", wr_reg, 9);
    chk("R4 data field", wr_dat, 16'hA5C3);
    chk("R1 driven bits write", oe_rises, 64);
    chk("R4 trailing clocks", rel_rises, 2);
    chk("R7 busy write", busy_cyc, 66 * 2 * CLK_DIV);
    run_op(0, 6'(PHY), 6'd9, 0);
    chk("R3 readback", rdata, 16'hA5C3);
    run_op(0, 6'(PHY), 6'd31, 0);
    chk("R3 read reg 31", rdata, {5'd31, 6'b101100, 5'd0});
  endtask

  task automatic t_absent;
    run_op(0, 6'd7, 6'd1, 0);
    chk("R3 absent phy", rdata, 16'hFFFF);
  endtask

  task automatic t_busy_ignore;
    int ws = wr_seen;
    @(negedge clk); req = 1; wr = 1; phy_a = 6'(PHY); loc = 6'd4; wd = 16'h1111;
    @(negedge clk); req = 0;
    repeat (300) @(negedge clk);
    req = 1; wd = 16'h2222; loc = 6'd5;
    @(negedge clk); req = 0;
    while (busy) @(negedge clk);
    repeat (5) @(negedge clk);
    chk("R7 one write only", wr_seen, ws + 1);
    chk("R7 first data kept", phy_regs[4], 16'h1111);
    chk("R7 second ignored", phy_regs[5], {5'd5, 6'b101100, ~5'd5});
  endtask

  task automatic local_op(input logic w, input logic [5:0] l, input logic [15:0] d);
    @(negedge clk); req = 1; wr = w; phy_a = 6'd32; loc = l; wd = d;
    @(negedge clk); req = 0;
  endtask

  task automatic t_local;
    int me = 0;
    logic [15:0] exp [8];
    logic [5:0] map [8];
    map = '{6'd0, 6'd1, 6'd2, 6'd3, 6'd4, 6'd5, 6'd16, 6'd17};
    for (int i = 0; i < 8; i++) begin
      exp[i] = 16'h1000 + 16'(i * 16'h0111);
      local_op(1, map[i], exp[i]);
      if (busy || mdc) me++;
    end
    local_op(1, 6'd7, 16'hFFFF);
    local_op(1, 6'd18, 16'hFFFF);
    local_op(1, 6'd32, 16'hFFFF);
    for (int i = 0; i < 8; i++) begin
      local_op(0, map[i], 0);
      chk("R8 local slot", rdata, exp[i]);
      if (busy || mdc || mdoe) me++;
    end
    local_op(0, 6'd7, 0);
    chk("R9 unmapped read", rdata, 0);
    local_op(0, 6'd32, 0);
    chk("R9 loc 32 read", rdata, 0);
    chk("R11 no bus on local", me, 0);
  endtask

  task automatic t_reject;
    int rs = rd_seen, act = 0;
    logic [15:0] keep;
    run_op(0, 6'(PHY), 6'd1, 0);
    keep = rdata; rs = rd_seen;
    @(negedge clk); req = 1; wr = 0; phy_a = 6'(PHY); loc = 6'd33;
    @(negedge clk); req = 0;
    repeat (60) begin if (busy || mdc) act++; @(negedge clk); end
    @(negedge clk); req = 1; phy_a = 6'd40; loc = 6'd1;
    @(negedge clk); req = 0;
    repeat (60) begin if (busy || mdc) act++; @(negedge clk); end
    chk("R10 no activity", act, 0);
    chk("R10 no frame", rd_seen, rs);
    chk("R10 rdata kept", rdata, keep);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_read_ext;
    t_write_ext;
    t_absent;
    t_busy_ignore;
    t_local;
    t_reject;
    chk("R6 data stable at rise", r6_viol, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule